// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block is the processor-facing register port of a display controller. A host reaches it over a byte-wide asynchronous bus. The bus may use separate active-low read and write strobes, or it may use a single active-high enable with a read/write direction line. A two-bit strap picks which of these conventions the strobe pins follow. Chip select, one address bit and the strobe pins together select one of four accesses: status read, memory-data read, data/argument write and command write.

Every access finishes within the host's own bus cycle, and the host sees no wait or handshake line. Read data is steered onto the bus combinationally while the read is in progress. Writes are carried into the core clock through two-flop synchronizers and are acted on once, when the strobe ends. Command writes come out as a single-cycle pulse that carries the code. Argument writes come out as pulses that carry the byte and an index: the index restarts at zero after each accepted command and stops at its top value. While the block is in its low-power state, only the setup and sleep-entry command codes get through. Any other command is dropped, and so are the argument bytes that follow it.

Top module: `hostbus_if`

## Requirements
- R1: With `mode_sel` = 2'b00 the strobe pins follow the split convention: `strb_a` is an active-low read and `strb_b` is an active-low write. A read with `bus_a0`=0 is a status read and a read with `bus_a0`=1 is a memory-data read. A write with `bus_a0`=0 is an argument write and a write with `bus_a0`=1 is a command write.
- R2: With any other `mode_sel` value, `strb_a` is an active-high enable and `strb_b` is the direction (1 = read, 0 = write). The four accesses map to `bus_a0` exactly as in R1.
- R3: `bus_oe` is high only while `bus_cs_n` is low and a read is in progress. At all other times `bus_oe` is low and `bus_dout` is zero.
- R4: During a status read, `bus_dout` bit 6 equals `retrace` and every other bit is 0.
- R5: During a memory-data read, `bus_dout` equals `rd_data`. Each such read produces exactly one `rd_next` pulse after the strobe ends.
- R6: An accepted command write produces exactly one single-cycle `cmd_valid` pulse, with `cmd_code` equal to the byte that was written.
- R7: After an accepted command, each argument write produces one `arg_valid` pulse carrying its byte. `arg_index` counts 0, 1, 2 and so on, and holds at 2^IDX_W-1 (7 by default). An argument write before any command is numbered from 0.
- R8: Command code 0x53 sets `asleep` and command code 0x40 clears it. Both codes are accepted whether or not the block is asleep. `asleep` is 0 after reset.
- R9: While `asleep` is 1, a command with any other code produces no `cmd_valid` and leaves `asleep` set. Argument writes that follow it produce no `arg_valid` until the next accepted command.
- R10: A transaction is acted on once per strobe, after the strobe is released. `cmd_valid`, `arg_valid` and `rd_next` are single-cycle pulses, and no two of them are high in the same cycle. A status read produces none of them.
- R11: Strobe activity while `bus_cs_n` is high produces no pulse and does not raise `bus_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Strap selecting the strobe convention (2'b00 = split strobes) |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_a0 | input | 1 | Address bit choosing status/argument against data/command |
| strb_a | input | 1 | Read strobe (split) or enable (combined) |
| strb_b | input | 1 | Write strobe (split) or direction (combined) |
| bus_din | input | 8 | Write data from the host |
| bus_dout | output | 8 | Read data toward the host |
| bus_oe | output | 1 | Drive enable for the bidirectional data pads |
| retrace | input | 1 | High while the display is in retrace |
| rd_data | input | 8 | Next memory byte from the memory sequencer |
| rd_next | output | 1 | Pulse: one memory-data read completed |
| cmd_valid | output | 1 | Pulse: accepted command |
| cmd_code | output | 8 | Code of the last accepted command |
| arg_valid | output | 1 | Pulse: accepted argument/data byte |
| arg_index | output | 3 | Position of the argument after its command |
| arg_byte | output | 8 | Argument/data byte |
| asleep | output | 1 | Low-power state flag |

## Verification
The hardest state to reach from the ports is an argument write that arrives while the block is asleep, after a non-wake command has been refused. A pulse-free result there looks exactly like a broken decoder unless the refusal came first. The random stimulus therefore picks the sleep and setup codes on half of its command writes, so the block spends long stretches asleep, and it keeps track of whether the latest command was accepted. Between accesses it also swaps the strobe convention, with chip select high and the pins parked at the new idle levels. This makes both conventions meet every sleep and index state.

// File: rtl/hbi_pkg.sv
`timescale 1ns/1ps
package hbi_pkg;
  typedef enum logic [1:0] {XF_STAT, XF_DRD, XF_ARG, XF_CMD} xfer_e;

  function automatic logic split_mode(input logic [1:0] sel);
    return sel == 2'b00;
  endfunction

  function automatic xfer_e kind_of(input logic a0, input logic is_rd);
    if (is_rd) return a0 ? XF_DRD : XF_STAT;
    return a0 ? XF_CMD : XF_ARG;
  endfunction

  function automatic logic [7:0] status_byte(input logic rt);
    logic [7:0] s;
    s = '0;
    s[6] = rt;
    return s;
  endfunction

  function automatic logic cmd_ok(input logic slp, input logic [7:0] code,
                                  input logic [7:0] wake, input logic [7:0] nap);
    return !slp || code == wake || code == nap;
  endfunction
endpackage

// File: rtl/hbi_sync.sv
`timescale 1ns/1ps
module hbi_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/hbi_decode.sv
`timescale 1ns/1ps
module hbi_decode
  import hbi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          split,
  input  logic          cs_n,
  input  logic          a0,
  input  logic          sa,
  input  logic          sb,
  input  logic [DW-1:0] din,
  output logic          fire,
  output xfer_e         fire_kind,
  output logic [DW-1:0] fire_byte
);
  logic act, is_rd, prev_act;

  assign act   = !cs_n && (split ? (!sa || !sb) : sa);
  assign is_rd = split ? !sa : sb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act  <= 1'b0;
      fire_kind <= XF_STAT;
      fire_byte <= '0;
    end else begin
      prev_act <= act;
      if (act) begin
        fire_kind <= kind_of(a0, is_rd);
        fire_byte <= din;
      end
    end
  end

  assign fire = prev_act && !act;
endmodule

// File: rtl/hbi_cmdfilt.sv
`timescale 1ns/1ps
module hbi_cmdfilt
  import hbi_pkg::*;
#(
  parameter int DW = 8,
  parameter int IDX_W = 3,
  parameter logic [7:0] WAKE_CODE = 8'h40,
  parameter logic [7:0] NAP_CODE  = 8'h53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  xfer_e            fire_kind,
  input  logic [DW-1:0]    fire_byte,
  output logic             cmd_valid,
  output logic [DW-1:0]    cmd_code,
  output logic             arg_valid,
  output logic [IDX_W-1:0] arg_index,
  output logic [DW-1:0]    arg_byte,
  output logic             rd_next,
  output logic             asleep
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  logic [IDX_W-1:0] idx;
  logic             accepted;
  logic             ok;

  assign ok = cmd_ok(asleep, fire_byte[7:0], WAKE_CODE, NAP_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      arg_valid <= 1'b0;
      arg_index <= '0;
      arg_byte  <= '0;
      rd_next   <= 1'b0;
      asleep    <= 1'b0;
      idx       <= '0;
      accepted  <= 1'b1;
    end else begin
      cmd_valid <= 1'b0;
      arg_valid <= 1'b0;
      rd_next   <= 1'b0;
      if (fire) begin
        unique case (fire_kind)
          XF_CMD: begin
            accepted <= ok;
            if (ok) begin
              cmd_valid <= 1'b1;
              cmd_code  <= fire_byte;
              idx       <= '0;
              if (fire_byte[7:0] == NAP_CODE)  asleep <= 1'b1;
              if (fire_byte[7:0] == WAKE_CODE) asleep <= 1'b0;
            end
          end
          XF_ARG: begin
            if (accepted) begin
              arg_valid <= 1'b1;
              arg_byte  <= fire_byte;
              arg_index <= idx;
              if (idx != IDX_MAX) idx <= idx + 1'b1;
            end
          end
          XF_DRD:  rd_next <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hostbus_if.sv
`timescale 1ns/1ps
module hostbus_if
  import hbi_pkg::*;
#(
  parameter int DW = 8,
  parameter int IDX_W = 3,
  parameter logic [7:0] WAKE_CODE = 8'h40,
  parameter logic [7:0] NAP_CODE  = 8'h53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             bus_cs_n,
  input  logic             bus_a0,
  input  logic             strb_a,
  input  logic             strb_b,
  input  logic [DW-1:0]    bus_din,
  output logic [DW-1:0]    bus_dout,
  output logic             bus_oe,
  input  logic             retrace,
  input  logic [DW-1:0]    rd_data,
  output logic             rd_next,
  output logic             cmd_valid,
  output logic [DW-1:0]    cmd_code,
  output logic             arg_valid,
  output logic [IDX_W-1:0] arg_index,
  output logic [DW-1:0]    arg_byte,
  output logic             asleep
);
  localparam int SW = DW + 4;
  localparam logic [SW-1:0] SYNC_RST = SW'(1) << (SW - 1);

  logic          split;
  logic [SW-1:0] sync_q;
  logic          fire;
  xfer_e         fire_kind;
  logic [DW-1:0] fire_byte;
  logic          rd_live;
  logic [DW-1:0] stat;

  assign split = split_mode(mode_sel);

  hbi_sync #(.W(SW), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({bus_cs_n, bus_a0, strb_a, strb_b, bus_din}),
    .q(sync_q)
  );

  hbi_decode #(.DW(DW)) dec_i (
    .clk(clk), .rst_n(rst_n), .split(split),
    .cs_n(sync_q[SW-1]), .a0(sync_q[SW-2]),
    .sa(sync_q[SW-3]), .sb(sync_q[SW-4]), .din(sync_q[DW-1:0]),
    .fire(fire), .fire_kind(fire_kind), .fire_byte(fire_byte)
  );

  hbi_cmdfilt #(.DW(DW), .IDX_W(IDX_W), .WAKE_CODE(WAKE_CODE), .NAP_CODE(NAP_CODE)) flt_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_kind(fire_kind), .fire_byte(fire_byte),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .arg_valid(arg_valid),
    .arg_index(arg_index), .arg_byte(arg_byte), .rd_next(rd_next), .asleep(asleep)
  );

  assign stat     = DW'(status_byte(retrace));
  assign rd_live  = !bus_cs_n && (split ? !strb_a : (strb_a && strb_b));
  assign bus_oe   = rd_live;
  assign bus_dout = !rd_live ? '0 : (bus_a0 ? rd_data : stat);
endmodule

// File: rtl/hbi_chk.sv
`timescale 1ns/1ps
module hbi_chk #(
  parameter int DW = 8,
  parameter logic [7:0] WAKE_CODE = 8'h40,
  parameter logic [7:0] NAP_CODE  = 8'h53
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_cs_n,
  input logic          bus_oe,
  input logic          cmd_valid,
  input logic [DW-1:0] cmd_code,
  input logic          arg_valid,
  input logic          rd_next,
  input logic          asleep
);
  p_oe_needs_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !bus_cs_n);
  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, arg_valid, rd_next}));
  p_cmd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_arg_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arg_valid |=> !arg_valid);
  p_nap_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[7:0] == NAP_CODE) |-> asleep);
  p_wake_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[7:0] == WAKE_CODE) |-> !asleep);
  p_filter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && $past(asleep)) |-> (cmd_code[7:0] == WAKE_CODE || cmd_code[7:0] == NAP_CODE));
endmodule

bind hostbus_if hbi_chk #(.DW(DW), .WAKE_CODE(WAKE_CODE), .NAP_CODE(NAP_CODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_oe(bus_oe),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .arg_valid(arg_valid),
  .rd_next(rd_next), .asleep(asleep)
);

// File: tb/hostbus_if_tb.sv
`timescale 1ns/1ps
module hostbus_if_tb_top;
  localparam logic [7:0] WAKE = 8'h40;
  localparam logic [7:0] NAP  = 8'h53;
  localparam int IMAX = 7;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode_sel = 2'b00;
  logic bus_cs_n = 1, bus_a0 = 0, strb_a = 1, strb_b = 1, retrace = 0;
  logic [7:0] bus_din = 0, rd_data = 0;
  logic [7:0] bus_dout, cmd_code, arg_byte;
  logic [2:0] arg_index;
  logic bus_oe, rd_next, cmd_valid, arg_valid, asleep;

  hostbus_if dut_i (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int n_cmd = 0, n_arg = 0, n_rd = 0;
  logic [7:0] l_cmd, l_arg;
  int l_idx;

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin n_cmd++; l_cmd = cmd_code; end
    if (arg_valid) begin n_arg++; l_arg = arg_byte; l_idx = int'(arg_index); end
    if (rd_next) n_rd++;
  end

  bit m_sleep = 0, m_acc = 1;
  int m_idx = 0;

  function automatic logic [7:0] f_status(input logic rt);
    return rt ? 8'b0100_0000 : 8'b0;
  endfunction
  function automatic bit f_allowed(input bit slp, input logic [7:0] c);
    return !slp || c == WAKE || c == NAP;
  endfunction
  function automatic bit f_split(input logic [1:0] s);
    return s == 2'b00;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic park_idle();
    strb_a = f_split(mode_sel) ? 1'b1 : 1'b0;
    strb_b = 1'b1;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(posedge clk); #1;
    bus_cs_n = 1; strb_a = 0; strb_b = 1;
    mode_sel = m; park_idle();
    repeat (4) @(posedge clk);
  endtask

  // kind: 0 status, 1 data read, 2 arg write, 3 cmd write
  task automatic access(input int kind, input logic [7:0] d, input bit cs);
    bit rd; int c0, a0c, r0; string rq;
    rd = kind < 2;
    c0 = n_cmd; a0c = n_arg; r0 = n_rd;
    @(posedge clk); #1;
    bus_a0 = (kind == 1 || kind == 3); bus_din = d; bus_cs_n = !cs;
    if (!f_split(mode_sel)) strb_b = rd;
    @(posedge clk); #1;
    if (f_split(mode_sel)) begin if (rd) strb_a = 0; else strb_b = 0; end
    else strb_a = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rq = f_split(mode_sel) ? "R1" : "R2";
    if (!cs) chk(bus_oe == 0, "R11", "oe with cs high", bus_oe, 0);
    else chk(bus_oe == rd, "R3", "oe during strobe", bus_oe, rd);
    if (cs && kind == 0) chk(bus_dout == f_status(retrace), "R4", "status byte", bus_dout, f_status(retrace));
    if (cs && kind == 1) chk(bus_dout == rd_data, "R5", "read data", bus_dout, rd_data);
    if (!(cs && rd)) chk(bus_dout == 0, "R3", "dout idle", bus_dout, 0);
    @(posedge clk); #1;
    park_idle();
    @(posedge clk); #1;
    bus_cs_n = 1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(bus_oe == 0, "R3", "oe after access", bus_oe, 0);
    if (!cs) begin
      chk((n_cmd - c0) + (n_arg - a0c) + (n_rd - r0) == 0, "R11", "pulses with cs high",
          (n_cmd - c0) + (n_arg - a0c) + (n_rd - r0), 0);
      return;
    end
    case (kind)
      0: chk((n_cmd - c0) + (n_arg - a0c) + (n_rd - r0) == 0, "R10", "status pulses",
             (n_cmd - c0) + (n_arg - a0c) + (n_rd - r0), 0);
      1: begin
        chk(n_rd - r0 == 1, "R5", "rd_next count", n_rd - r0, 1);
        chk(n_cmd == c0 && n_arg == a0c, rq, "read decoded as write", n_cmd - c0 + n_arg - a0c, 0);
      end
      2: begin
        chk(n_arg - a0c == (m_acc ? 1 : 0), m_acc ? "R7" : "R9", "arg count", n_arg - a0c, m_acc);
        chk(n_cmd == c0 && n_rd == r0, rq, "arg decoded wrong", n_cmd - c0 + n_rd - r0, 0);
        if (m_acc) begin
          chk(l_arg == d, "R7", "arg byte", l_arg, d);
          chk(l_idx == m_idx, "R7", "arg index", l_idx, m_idx);
          if (m_idx < IMAX) m_idx++;
        end
      end
      default: begin
        bit ok = f_allowed(m_sleep, d);
        chk(n_cmd - c0 == (ok ? 1 : 0), ok ? "R6" : "R9", "cmd count", n_cmd - c0, ok);
        chk(n_arg == a0c && n_rd == r0, rq, "cmd decoded wrong", n_arg - a0c + n_rd - r0, 0);
        m_acc = ok;
        if (ok) begin
          chk(l_cmd == d, "R6", "cmd code", l_cmd, d);
          m_idx = 0;
          if (d == NAP) m_sleep = 1;
          if (d == WAKE) m_sleep = 0;
        end
        chk(asleep == m_sleep, "R8", "asleep flag", asleep, m_sleep);
      end
    endcase
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk); #1 rst_n = 1;
    repeat (2) @(negedge clk);
    chk(asleep == 0 && cmd_valid == 0 && arg_valid == 0 && rd_next == 0 && bus_oe == 0,
        "R8", "reset state", {asleep, cmd_valid, arg_valid, rd_next, bus_oe}, 0);
    // split convention, directed
    access(2, 8'h11, 1);            // R7 arg before any command is index 0
    access(3, 8'h81, 1);            // R6
    for (int i = 0; i < 10; i++) access(2, 8'(i + 8'h20), 1); // R7 saturation
    retrace = 1; access(0, 0, 1);   // R4
    retrace = 0; access(0, 0, 1);
    rd_data = 8'hA5; access(1, 0, 1); // R5
    access(3, 8'h81, 0);            // R11
    access(0, 0, 0);                // R11
    access(3, NAP, 1);              // R8
    access(3, 8'h44, 1);            // R9 refused
    access(2, 8'h55, 1);            // R9 arg dropped
    access(3, NAP, 1);              // R8 nap accepted while asleep
    access(3, WAKE, 1);             // R8
    // combined convention, directed
    set_mode(2'b10);
    access(3, 8'h42, 1);            // R2
    access(2, 8'h66, 1);
    rd_data = 8'h3C; access(1, 0, 1);
    retrace = 1; access(0, 0, 1);
    access(1, 0, 0);                // R11
    // random mix
    for (int n = 0; n < 300; n++) begin
      int k, r;
      logic [7:0] d;
      if ($urandom % 16 == 0) set_mode(2'($urandom));
      retrace = 1'($urandom);
      rd_data = 8'($urandom);
      k = int'($urandom % 4);
      r = int'($urandom % 4);
      d = (k == 3 && r == 0) ? WAKE : (k == 3 && r == 1) ? NAP : 8'($urandom);
      access(k, d, ($urandom % 10) != 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule